// File: doc/BRIEF.md
# RC Time-Constant Capacitance Counter

This block turns the charging time of an RC network into an 8-bit number that is proportional to the unknown capacitance. An external comparator front end drives two indicator lines. The first line is high while the capacitor voltage sits near zero, which means the capacitor is discharged and a measurement can begin. The second line goes high once the voltage passes roughly 63 % of the supply, which happens one time constant after charging starts. The block counts clock ticks between the fall of the discharged indicator and the rise of the threshold indicator. It holds that count as the result.

Because the count measures RC in units of the tick period, the capacitance follows from C = result × Tclk × PRESCALE / R. One least significant bit therefore stands for Tclk × PRESCALE / R farads. The PRESCALE parameter sets how many clocks make one tick, which selects the measurable range. If the count would pass 255, it stops at 255 and an overflow flag rises. If the threshold line is already high when counting should start, the block reports zero and raises an error flag. Both indicator lines are asynchronous, so each one passes through a two-flop synchronizer. Both lines see the same delay, which keeps the measured interval exact.

Top module: `rc_cap_meter`

## Requirements
- R1: After reset, `result` is 0 and `done`, `overflow` and `early_err` are all 0.
- R2: While `empty_in` is high, the block is armed: `result` reads 0, and `done`, `overflow` and `early_err` read 0, starting at most 3 clocks after `empty_in` rises.
- R3: With PRESCALE = 1, let N be the number of clock cycles from the fall of `empty_in` to the rise of `thresh_in`. Then `result` equals N and `done` is 1, starting 3 clocks after `thresh_in` rises.
- R4: Once `done` is 1, `done` and `result` hold, and changes on `thresh_in` have no effect, until `empty_in` rises again.
- R5: The count saturates rather than wrapping. With N = 255 the result is 255 and `overflow` is 0. With N ≥ 256 the result is 255 and `overflow` is 1.
- R6: If `thresh_in` is already high when `empty_in` falls, the block ends with `result` = 0, `done` = 1 and `early_err` = 1.
- R7: With PRESCALE = P, the result equals floor(N / P), saturating at 255.
- R8: If the block was never armed after reset, a rise of `thresh_in` leaves `done` at 0 and `result` at 0.
- R9: Raising `empty_in` after a finished measurement clears the previous result and flags, and the next measurement starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period sets the time base |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_in | input | 1 | Asynchronous indicator: capacitor has passed one time constant |
| empty_in | input | 1 | Asynchronous indicator: capacitor voltage near zero |
| result | output | 8 | Tick count proportional to capacitance |
| done | output | 1 | Measurement finished; result is valid |
| overflow | output | 1 | Count saturated at 255 |
| early_err | output | 1 | Threshold was already high when counting should have started |

## Verification
The assertions assume that the front end follows the physical order. The discharged indicator is high before each measurement, and the threshold indicator rises only after the discharged indicator falls, except in the deliberate early-threshold case. The stimulus changes both lines only on falling clock edges. Each line stays at a level for at least several cycles, so every change passes cleanly through the synchronizers. The stimulus also always re-arms through a high phase of the discharged indicator before it starts a new interval.

// File: rtl/rc_cap_meter.sv
module rc_cap_meter #(
  parameter int PRESCALE = 1,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thresh_in,
  input  logic             empty_in,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overflow,
  output logic             early_err
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_COUNT, S_DONE} st_t;
  st_t st;

  logic [1:0] thr_sync, emp_sync;
  logic thr_s, emp_s;
  logic [PW-1:0] pre;
  logic tick, arm_go, adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_sync <= '0;
      emp_sync <= '0;
    end else begin
      thr_sync <= {thr_sync[0], thresh_in};
      emp_sync <= {emp_sync[0], empty_in};
    end
  end

  assign thr_s  = thr_sync[1];
  assign emp_s  = emp_sync[1];
  assign tick   = (pre == PW'(PRESCALE - 1));
  assign arm_go = (st == S_IDLE || st == S_DONE) && emp_s;
  assign adv    = !thr_s && ((st == S_COUNT) || (st == S_ARMED && !emp_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      early_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (emp_s) st <= S_ARMED;
        S_ARMED: if (!emp_s) begin
                   if (thr_s) begin
                     st        <= S_DONE;
                     early_err <= 1'b1;
                   end else begin
                     st <= S_COUNT;
                   end
                 end
        S_COUNT: if (thr_s) st <= S_DONE;
        S_DONE:  if (emp_s) begin
                   st        <= S_ARMED;
                   early_err <= 1'b0;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || arm_go || (st == S_ARMED && emp_s)) begin
      pre <= '0;
      if (!rst_n || arm_go) begin
        result   <= '0;
        overflow <= 1'b0;
      end
    end else if (adv) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        if (result == CMAX) overflow <= 1'b1;
        else                result   <= result + 1'b1;
      end
    end
  end

  assign done = (st == S_DONE);

  a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !emp_s) |=> (done && $stable(result)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COUNT) |=> (result >= $past(result)));

  a_r5_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result == CMAX));

  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    early_err |-> (result == '0 && done));

  a_r2_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED) |-> (result == '0 && !overflow && !early_err && !done));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!done && result == '0));
endmodule

// File: tb/tb_rc_cap_meter.sv
module tb_rc_cap_meter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thresh_in = 1'b0;
  logic empty_in = 1'b0;
  logic [7:0] result, result4;
  logic done, overflow, early_err, done4, overflow4, early_err4;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_cap_meter dut (
    .clk(clk), .rst_n(rst_n), .thresh_in(thresh_in), .empty_in(empty_in),
    .result(result), .done(done), .overflow(overflow), .early_err(early_err));

  rc_cap_meter #(.PRESCALE(4)) dut4 (
    .clk(clk), .rst_n(rst_n), .thresh_in(thresh_in), .empty_in(empty_in),
    .result(result4), .done(done4), .overflow(overflow4), .early_err(early_err4));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm();
    empty_in = 1'b1;
    wait_cyc(2);
    thresh_in = 1'b0;
    wait_cyc(4);
    chk("R2 result", result, 0);
    chk("R2 done", done, 0);
    chk("R2 flags", {overflow, early_err}, 0);
  endtask

  task automatic measure(input int n);
    arm();
    empty_in = 1'b0;
    wait_cyc(n);
    thresh_in = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    chk("R1 result", result, 0);
    chk("R1 flags", {done, overflow, early_err}, 0);
  endtask

  task automatic t_idle_ignore();
    thresh_in = 1'b1;
    wait_cyc(6);
    chk("R8 done", done, 0);
    chk("R8 result", result, 0);
    thresh_in = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_basic();
    measure(17);
    chk("R3 result N=17", result, 17);
    chk("R3 done", done, 1);
    chk("R7 result4 N=17", result4, 4);
    measure(1);
    chk("R3 result N=1", result, 1);
    measure(100);
    chk("R3 result N=100", result, 100);
    chk("R7 result4 N=100", result4, 25);
  endtask

  task automatic t_hold();
    measure(42);
    thresh_in = 1'b0;
    wait_cyc(6);
    chk("R4 done held", done, 1);
    chk("R4 result held", result, 42);
    thresh_in = 1'b1;
    wait_cyc(6);
    chk("R4 result after toggle", result, 42);
  endtask

  task automatic t_saturate();
    measure(255);
    chk("R5 result N=255", result, 255);
    chk("R5 no ovf N=255", overflow, 0);
    measure(256);
    chk("R5 result N=256", result, 255);
    chk("R5 ovf N=256", overflow, 1);
    measure(400);
    chk("R5 result N=400", result, 255);
    chk("R5 ovf N=400", overflow, 1);
    chk("R7 result4 N=400", result4, 100);
  endtask

  task automatic t_early();
    arm();
    thresh_in = 1'b1;
    wait_cyc(4);
    empty_in = 1'b0;
    wait_cyc(6);
    chk("R6 result", result, 0);
    chk("R6 done", done, 1);
    chk("R6 err", early_err, 1);
  endtask

  task automatic t_rearm();
    measure(9);
    chk("R9 first", result, 9);
    measure(30);
    chk("R9 second", result, 30);
    chk("R9 err cleared", early_err, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_idle_ignore();
    t_basic();
    t_hold();
    t_saturate();
    t_early();
    t_rearm();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule